// File: doc/BRIEF.md
# Branch Trace History Queue

This block keeps a short history of program-flow changes for an on-chip debug unit. Each time the core reports a branch, the block captures a pair of values. The first is a source record: the last address fetched before the branch, plus a 3-bit pointer to the instruction buffer slot that held the last instruction executed. The second is a destination record: the fetch address of the branch target. The pair enters an eight-entry shift queue. Each new branch moves every older pair one slot deeper, and the oldest pair is discarded.

A debugger reads the queue through a combinational read port. `rd_idx` selects the entry, where 0 is the newest and 7 the oldest. `rd_sel` selects the source word or the destination word. The destination word carries a fresh-capture flag. A capture sets the flag, and a destination read strobe clears it. Resets clear only this flag; the captured addresses and pointers keep their values. The port also returns the decoded buffer number for the pointer of the selected entry. Reading never removes an entry. The port has no write path, so software cannot alter the history.

Top module: `brtrace_queue`

## Requirements
- R1: A cycle with `br_valid` high writes the inputs into entry 0, and entry i+1 takes the old contents of entry i. With 8 entries, entry 7 is the oldest and its old contents are dropped.
- R2: With `rd_sel`=0, `rd_data` is the source word of entry `rd_idx`: bit 31 is 0, bits 30:28 are the buffer pointer, and bits 27:0 are the source address.
- R3: With `rd_sel`=1, `rd_data` is the destination word of entry `rd_idx`: bit 31 is the fresh-capture flag, bits 30:28 are 0, and bits 27:0 are the destination address.
- R4: A capture sets the flag to 1 in the cycle after it.
- R5: A cycle with `rd_en`=1 and `rd_sel`=1 clears the flag, whatever the value of `rd_idx`. A read strobe with `rd_sel`=0 leaves the flag unchanged.
- R6: When a capture and a destination read strobe fall in the same cycle, the flag ends up 1.
- R7: `rst_n` low clears the flag at once. A `man_rst` cycle clears it at the next edge and overrides a capture in that cycle. The capture's data is still stored.
- R8: Neither reset changes the stored addresses or pointers.
- R9: Read strobes do not change the queue contents.
- R10: `rd_buf_num` gives the pointer of the selected entry when the pointer is even, and (pointer+2) mod 8 when it is odd.
- R11: `rd_data` and `rd_buf_num` follow `rd_sel` and `rd_idx` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low (clears the flag only) |
| man_rst | input | 1 | Synchronous manual reset of the flag |
| br_valid | input | 1 | Branch event: capture and shift this cycle |
| br_src_addr | input | 28 | Last fetched address before the branch |
| br_buf_ptr | input | 3 | Instruction buffer pointer for the last executed instruction |
| br_dst_addr | input | 28 | Branch target fetch address |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 = source word, 1 = destination word |
| rd_idx | input | 3 | Entry select, 0 = newest |
| rd_data | output | 32 | Selected word |
| rd_buf_num | output | 3 | Decoded buffer number of the selected entry |

## Verification
The bench pushes twenty branches with arithmetically distinct fields, which is more than twice the depth. After every push it sweeps all live entries in both word formats. A shift bug, or a queue that does not drop its oldest entry, returns the wrong generation at some index. Because every pointer value appears, an odd-pointer decode without wrap shows up at pointer 7. The flag corner cases are probed one at a time: a source-read strobe, a destination read at a deep index, a capture and a read together, and a manual reset together with a capture. A design that gave the read priority, or let a source read clear the flag, would show the wrong bit 31. A design that reset the data would fail the content sweeps run after each reset.

// File: rtl/brq_pkg.sv
`timescale 1ns/1ps
package brq_pkg;
    localparam int ADDR_W = 28;
    localparam int PTR_W  = 3;
    localparam int WORD_W = 1 + PTR_W + ADDR_W;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } brq_entry_t;
endpackage

// File: rtl/brq_store.sv
`timescale 1ns/1ps
module brq_store
    import brq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       push,
    input  brq_entry_t new_ent,
    output brq_entry_t ent_o [DEPTH]
);
    typedef struct {
        brq_entry_t slot [DEPTH];
    } store_t;

    store_t st_d, st_q;

    // Shift network: slot 0 takes new data, each deeper slot takes its neighbour.
    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[0] = new_ent;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.slot[i] = st_q.slot[i-1];
            end
        end
    end

    // Data storage carries no reset: only the flag is initialised.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign ent_o[g] = st_q.slot[g];
    end
endmodule

// File: rtl/brq_flag.sv
`timescale 1ns/1ps
module brq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic man_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t fl_d, fl_q;

    // Priority: manual reset, then capture, then read clear.
    always_comb begin
        fl_d = fl_q;
        if (man_rst) begin
            fl_d.flag = 1'b0;
        end else if (set_i) begin
            fl_d.flag = 1'b1;
        end else if (clr_i) begin
            fl_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flag_o = fl_q.flag;
endmodule

// File: rtl/brq_bufdec.sv
`timescale 1ns/1ps
module brq_bufdec
    import brq_pkg::*;
(
    input  logic [PTR_W-1:0] ptr_i,
    output logic [PTR_W-1:0] buf_o
);
    localparam logic [PTR_W-1:0] ODD_OFS = PTR_W'(2);

    // Odd pointers name the slot two further on, wrapping modulo 2**PTR_W.
    always_comb begin
        if (ptr_i[0]) begin
            buf_o = ptr_i + ODD_OFS;
        end else begin
            buf_o = ptr_i;
        end
    end
endmodule

// File: rtl/brtrace_queue.sv
`timescale 1ns/1ps
module brtrace_queue
    import brq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              man_rst,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_src_addr,
    input  logic [PTR_W-1:0]  br_buf_ptr,
    input  logic [ADDR_W-1:0] br_dst_addr,
    input  logic              rd_en,
    input  logic              rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_buf_num
);
    brq_entry_t new_ent;
    brq_entry_t ent_q [DEPTH];
    brq_entry_t sel_ent;
    logic       flag_q;
    logic       dst_rd;

    assign new_ent.ptr = br_buf_ptr;
    assign new_ent.src = br_src_addr;
    assign new_ent.dst = br_dst_addr;
    assign dst_rd      = rd_en & rd_sel;

    brq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .push    (br_valid),
        .new_ent (new_ent),
        .ent_o   (ent_q)
    );

    brq_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .man_rst (man_rst),
        .set_i   (br_valid),
        .clr_i   (dst_rd),
        .flag_o  (flag_q)
    );

    always_comb begin
        sel_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                sel_ent = ent_q[i];
            end
        end
    end

    brq_bufdec u_dec (
        .ptr_i (sel_ent.ptr),
        .buf_o (rd_buf_num)
    );

    always_comb begin
        if (rd_sel) begin
            rd_data = {flag_q, {PTR_W{1'b0}}, sel_ent.dst};
        end else begin
            rd_data = {1'b0, sel_ent.ptr, sel_ent.src};
        end
    end
endmodule

// File: rtl/brq_checker.sv
`timescale 1ns/1ps
module brq_checker
    import brq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              man_rst,
    input logic              br_valid,
    input logic [ADDR_W-1:0] br_src_addr,
    input logic [PTR_W-1:0]  br_buf_ptr,
    input logic [ADDR_W-1:0] br_dst_addr,
    input logic              rd_en,
    input logic              rd_sel,
    input logic [WORD_W-1:0] rd_data,
    input logic              flag,
    input brq_entry_t        head,
    input brq_entry_t        second
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (br_valid) seen_q <= 1'b1;
    end

    a_r1_head_capture: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (head.src == $past(br_src_addr)) && (head.dst == $past(br_dst_addr))
                     && (head.ptr == $past(br_buf_ptr)));

    a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && seen_q) |=> second == $past(head));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && seen_q) |=> head == $past(head));

    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !man_rst) |=> flag);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel && !br_valid) |=> !flag);

    a_r5_src_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && !br_valid && !man_rst && flag) |=> flag);

    a_r7_man_rst: assert property (@(posedge clk) disable iff (!rst_n)
        man_rst |=> !flag);

    a_r3_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> (rd_data[WORD_W-2 -: PTR_W] == '0) && (rd_data[WORD_W-1] == flag));
endmodule

bind brtrace_queue brq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .man_rst     (man_rst),
    .br_valid    (br_valid),
    .br_src_addr (br_src_addr),
    .br_buf_ptr  (br_buf_ptr),
    .br_dst_addr (br_dst_addr),
    .rd_en       (rd_en),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .flag        (flag_q),
    .head        (ent_q[0]),
    .second      (ent_q[1])
);

// File: tb/brtrace_queue_test.sv
`timescale 1ns/1ps
module brtrace_queue_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        man_rst = 1'b0;
    logic        br_valid = 1'b0;
    logic [27:0] br_src_addr = '0;
    logic [2:0]  br_buf_ptr = '0;
    logic [27:0] br_dst_addr = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [2:0]  rd_buf_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    brtrace_queue #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .br_valid(br_valid),
        .br_src_addr(br_src_addr), .br_buf_ptr(br_buf_ptr), .br_dst_addr(br_dst_addr),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_buf_num(rd_buf_num)
    );

    function automatic logic [27:0] src_of(int k);
        return 28'(28'h1000000 + k * 28'h0012345);
    endfunction
    function automatic logic [27:0] dst_of(int k);
        return 28'(28'hABC0000 ^ (k * 28'h0101011));
    endfunction
    function automatic logic [2:0] ptr_of(int k);
        return 3'(k % 8);
    endfunction
    function automatic logic [2:0] buf_of(int k);
        int p = k % 8;
        return 3'((p % 2 == 1) ? (p + 2) % 8 : p);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(bit sel, int idx, output logic [31:0] w, output logic [2:0] b);
        rd_sel = sel;
        rd_idx = 3'(idx);
        #1;
        w = rd_data;
        b = rd_buf_num;
    endtask

    task automatic check_flag(bit exp, string req);
        logic [31:0] w;
        logic [2:0]  b;
        peek(1'b1, 0, w, b);
        check(w[31] == exp, req, {31'd0, w[31]}, {31'd0, exp});
    endtask

    // Entry j must hold generation newest-j for all live entries.
    task automatic sweep(int newest, int live, string req);
        logic [31:0] w;
        logic [2:0]  b;
        for (int j = 0; j < live; j++) begin
            int g = newest - j;
            peek(1'b0, j, w, b);
            check(w == {1'b0, ptr_of(g), src_of(g)}, {req, " src word"}, w, {1'b0, ptr_of(g), src_of(g)});
            check(b == buf_of(g), "R10 buffer decode", {29'd0, b}, {29'd0, buf_of(g)});
            peek(1'b1, j, w, b);
            check(w[30:0] == {3'b000, dst_of(g)}, {req, " dst word"}, {1'b0, w[30:0]}, {4'h0, dst_of(g)});
        end
    endtask

    task automatic push(int k, bit with_rd, bit with_mr);
        @(negedge clk);
        br_valid = 1'b1;
        br_src_addr = src_of(k);
        br_buf_ptr = ptr_of(k);
        br_dst_addr = dst_of(k);
        rd_en = with_rd;
        if (with_rd) rd_sel = 1'b1;
        man_rst = with_mr;
        @(negedge clk);
        br_valid = 1'b0;
        rd_en = 1'b0;
        man_rst = 1'b0;
    endtask

    task automatic strobe_read(bit sel, int idx);
        @(negedge clk);
        rd_en = 1'b1;
        rd_sel = sel;
        rd_idx = 3'(idx);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_flag(1'b0, "R7 flag clear under power-on reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_flag(1'b0, "R7 flag clear after reset");

        // R1 R2 R3 R4 R10 R11: pushes over twice the depth, full sweep each time
        for (int k = 0; k < 20; k++) begin
            push(k, 1'b0, 1'b0);
            check_flag(1'b1, "R4 capture sets flag");
            sweep(k, (k + 1 < DEPTH) ? k + 1 : DEPTH, "R1");
        end

        // R5: source read keeps the flag, destination read at a deep index clears it
        strobe_read(1'b0, 2);
        check_flag(1'b1, "R5 source read keeps flag");
        strobe_read(1'b1, 5);
        check_flag(1'b0, "R5 destination read clears flag");
        sweep(19, DEPTH, "R9 reads do not pop");

        // R6: capture and destination read together
        push(20, 1'b1, 1'b0);
        check_flag(1'b1, "R6 capture wins over read");
        sweep(20, DEPTH, "R1");

        // R7 R8: manual reset alone
        @(negedge clk);
        man_rst = 1'b1;
        @(negedge clk);
        man_rst = 1'b0;
        check_flag(1'b0, "R7 manual reset clears flag");
        sweep(20, DEPTH, "R8 manual reset keeps data");

        // R7: manual reset overrides a capture, data still stored
        push(21, 1'b0, 1'b1);
        check_flag(1'b0, "R7 manual reset beats capture");
        sweep(21, DEPTH, "R7 capture data under manual reset");

        // R7 R8: asynchronous reset mid-cycle
        push(22, 1'b0, 1'b0);
        check_flag(1'b1, "R4 capture sets flag");
        #3;
        rst_n = 1'b0;
        check_flag(1'b0, "R7 asynchronous reset clears flag at once");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_flag(1'b0, "R7 flag stays clear after reset");
        sweep(22, DEPTH, "R8 power-on reset keeps data");

        finish_run();
    end
endmodule